// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks, for every hardware thread of a multithreaded front end, which state the fetch engine is in. It also tracks whether any later pipeline stage is holding that thread back. Each cycle it folds together the hold and release pulses from the four downstream stages and a global context-switch hold. It also takes redirect requests from commit and from decode, a flag saying the reorder buffer is still flushing, fetch-side events (a line request launched, a refused request retried, a thread picked for fetch) and instruction-cache completions that carry a thread number and a request tag.

The block resolves competing signals with a fixed precedence. It filters out cache completions that no longer belong to the thread's outstanding request. It reports the resulting state per thread, the per-stage hold flags, a one-cycle pulse whenever a thread reported a status change, and a stage-level activity flag. The activity flag is only re-evaluated on cycles that carry such a change. The branch predictor, next-PC arithmetic and the cache are outside the block. The block only captures the redirect PC and flags that a redirect happened.

All event inputs are single-cycle, valid-qualified pulses with no ready. The block consumes every pulse in the cycle it is presented and never exerts back-pressure. All outputs are registered, so an input applied before a clock edge is visible on the outputs just after that edge.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread reads Running, all hold flags and line-valid bits are 0, stage_active_o is 1 and status_chg_o is 0. Status codes on status_o (4 bits per thread, thread t at bits 4t+3..4t) are: Idle 0, Running 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessDone 6, TrapPending 7, QuiescePending 8.
- R2: Bit 4t+s of stall_set_i sets, and of stall_clr_i clears, the hold flag of thread t for stage s (s = 0 decode, 1 rename, 2 execute, 3 commit), visible on the same bit of stall_flags_o. A clear never coincides with a set of the same bit and only arrives while the flag is set.
- R3: A commit redirect outranks every other input. It moves the thread to Squashing, pulses redirect_o with the commit PC and reports a change. Any outstanding cache request is abandoned, so its later completion is dropped.
- R4: Failing R3, a reorder-buffer-flushing flag holds the thread in Squashing and reports a change, without a redirect.
- R5: Failing R3 and R4, a decode redirect moves a thread that is not already Squashing to Squashing, with redirect_o and the decode PC. For a thread already Squashing it is ignored: there is no redirect, and the lower rules apply.
- R6: Failing R3 to R5, any hold flag of the thread (after this cycle's pulses) or ctx_stall_i moves the thread to Blocked and reports a change, unless it is in WaitResponse or WaitRetry, which stay put without a change.
- R7: Failing R3 to R6, a Blocked or Squashing thread returns to Running with a change. Any other state is kept and no change is reported.
- R8: A launch for a thread whose status after R3 to R7 is Running moves it to WaitResponse, or to WaitRetry when lreq_refused_i is 1. It records the tag, clears the line-valid bit and reports a change. A launch for a thread in any other state is ignored.
- R9: retry_grant_i moves a WaitRetry thread to WaitResponse without reporting a change.
- R10: A completion whose thread is in WaitResponse with a matching tag sets line_valid_o. It moves the thread to Blocked if any hold applies, else to AccessDone. If no change is reported that cycle, it sets stage_active_o.
- R11: Any other completion is dropped: stale_drop_o pulses and the thread state is untouched.
- R12: An AccessDone thread becomes Running, with a change, only when it is picked through fsel.
- R13: On a cycle with a reported change, stage_active_o is set to whether any thread ends the cycle Running, Squashing or AccessDone. Otherwise it holds (except as R10 says).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_set_i | input | 4*NUM_THREADS | Per thread and stage hold pulse |
| stall_clr_i | input | 4*NUM_THREADS | Per thread and stage release pulse |
| ctx_stall_i | input | 1 | Global context-switch hold |
| cmt_squash_i | input | NUM_THREADS | Commit redirect per thread |
| cmt_pc_i | input | PC_W*NUM_THREADS | Commit redirect PC per thread |
| rob_squashing_i | input | NUM_THREADS | Reorder buffer still flushing |
| dec_squash_i | input | NUM_THREADS | Decode redirect per thread |
| dec_pc_i | input | PC_W*NUM_THREADS | Decode redirect PC per thread |
| fsel_valid_i | input | 1 | A thread is picked for fetch |
| fsel_tid_i | input | TID_W | Picked thread |
| lreq_valid_i | input | 1 | Line request launched |
| lreq_tid_i | input | TID_W | Launching thread |
| lreq_tag_i | input | TAG_W | Tag of the launched request |
| lreq_refused_i | input | 1 | Cache refused the request |
| retry_grant_i | input | NUM_THREADS | Refused request now accepted |
| cmpl_valid_i | input | 1 | Cache completion |
| cmpl_tid_i | input | TID_W | Completion thread |
| cmpl_tag_i | input | TAG_W | Completion tag |
| status_o | output | 4*NUM_THREADS | Per-thread status code |
| stall_flags_o | output | 4*NUM_THREADS | Per-thread, per-stage hold flags |
| line_valid_o | output | NUM_THREADS | Fetched line present |
| redirect_o | output | NUM_THREADS | Redirect pulse |
| redirect_pc_o | output | PC_W*NUM_THREADS | Captured redirect PC |
| status_chg_o | output | 1 | Some thread reported a change |
| stage_active_o | output | 1 | Stage-level activity flag |
| stale_drop_o | output | 1 | A completion was discarded |

## Verification
The precedence chain is exercised with single sources and with stacked sources in one cycle: a commit redirect together with a decode redirect and a flushing flag, and a commit redirect on a thread that is also held. These stacks show whether the order is right and not merely whether each rule works alone. Completions are sent with a wrong tag, to the wrong thread, after a redirect abandoned the request, and with a hold active. Each case separates tag filtering from state filtering and from the Blocked/AccessDone choice. Activity is driven so that both threads wait on the cache, which clears the flag. A later completion must then raise it on a cycle with no reported change.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int NUM_STAGES = 4;
  localparam int STG_DEC    = 0;
  localparam int STG_REN    = 1;
  localparam int STG_EXE    = 2;
  localparam int STG_CMT    = 3;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_RUN        = 4'd1,
    ST_SQUASH     = 4'd2,
    ST_BLOCK      = 4'd3,
    ST_WAIT_RESP  = 4'd4,
    ST_WAIT_RETRY = 4'd5,
    ST_ACC_DONE   = 4'd6,
    ST_TRAP       = 4'd7,
    ST_QUIESCE    = 4'd8
  } fetch_st_e;

  function automatic logic st_is_live(fetch_st_e st);
    return (st == ST_RUN) || (st == ST_SQUASH) || (st == ST_ACC_DONE);
  endfunction

endpackage

// File: rtl/fsc_stall_bank.sv
module fsc_stall_bank #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_STAGES  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_THREADS*NUM_STAGES-1:0] set_i,
  input  logic [NUM_THREADS*NUM_STAGES-1:0] clr_i,
  output logic [NUM_THREADS*NUM_STAGES-1:0] flags_q_o,
  output logic [NUM_THREADS*NUM_STAGES-1:0] flags_nxt_o
);
  localparam int NBITS = NUM_THREADS * NUM_STAGES;

  logic [NBITS-1:0] flags_q;

  for (genvar b = 0; b < NBITS; b++) begin : g_flag
    // a release wins only because it never meets a set on the same bit
    assign flags_nxt_o[b] = (flags_q[b] | set_i[b]) & ~clr_i[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[b] <= 1'b0;
      else        flags_q[b] <= flags_nxt_o[b];
    end
  end

  assign flags_q_o = flags_q;

endmodule

// File: rtl/fsc_thread_ctl.sv
module fsc_thread_ctl
  import fsc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] flags_nxt_i,
  input  logic                  ctx_stall_i,
  input  logic                  cmt_squash_i,
  input  logic [PC_W-1:0]       cmt_pc_i,
  input  logic                  rob_squashing_i,
  input  logic                  dec_squash_i,
  input  logic [PC_W-1:0]       dec_pc_i,
  input  logic                  fsel_hit_i,
  input  logic                  lreq_hit_i,
  input  logic [TAG_W-1:0]      lreq_tag_i,
  input  logic                  lreq_refused_i,
  input  logic                  retry_grant_i,
  input  logic                  cmpl_hit_i,
  input  logic [TAG_W-1:0]      cmpl_tag_i,
  output fetch_st_e             st_o,
  output logic                  chg_o,
  output logic                  acc_o,
  output logic                  drop_o,
  output logic                  live_nxt_o,
  output logic                  line_valid_o,
  output logic                  redirect_o,
  output logic [PC_W-1:0]       redirect_pc_o
);

  fetch_st_e        st_q, st_sig, st_fet, st_nxt;
  logic             hold_any;
  logic             chg_sig, chg_fet;
  logic             ld_pc;
  logic [PC_W-1:0]  new_pc;
  logic [TAG_W-1:0] tag_q, tag_nxt;
  logic             lv_q, lv_clr;
  logic             redir_q;
  logic [PC_W-1:0]  redir_pc_q;

  assign hold_any = (|flags_nxt_i) | ctx_stall_i;

  // stage 1: redirect and hold precedence
  always_comb begin
    st_sig  = st_q;
    chg_sig = 1'b0;
    ld_pc   = 1'b0;
    new_pc  = '0;
    if (cmt_squash_i) begin
      st_sig  = ST_SQUASH;
      chg_sig = 1'b1;
      ld_pc   = 1'b1;
      new_pc  = cmt_pc_i;
    end else if (rob_squashing_i) begin
      st_sig  = ST_SQUASH;
      chg_sig = 1'b1;
    end else if (dec_squash_i && (st_q != ST_SQUASH)) begin
      st_sig  = ST_SQUASH;
      chg_sig = 1'b1;
      ld_pc   = 1'b1;
      new_pc  = dec_pc_i;
    end else if (hold_any && (st_q != ST_WAIT_RESP) && (st_q != ST_WAIT_RETRY)) begin
      st_sig  = ST_BLOCK;
      chg_sig = 1'b1;
    end else if ((st_q == ST_BLOCK) || (st_q == ST_SQUASH)) begin
      st_sig  = ST_RUN;
      chg_sig = 1'b1;
    end
  end

  // stage 2: fetch-side events act on the resolved state
  always_comb begin
    st_fet  = st_sig;
    chg_fet = 1'b0;
    tag_nxt = tag_q;
    lv_clr  = 1'b0;
    if (fsel_hit_i && (st_sig == ST_ACC_DONE)) begin
      st_fet  = ST_RUN;
      chg_fet = 1'b1;
    end else if (lreq_hit_i && (st_sig == ST_RUN)) begin
      st_fet  = lreq_refused_i ? ST_WAIT_RETRY : ST_WAIT_RESP;
      chg_fet = 1'b1;
      tag_nxt = lreq_tag_i;
      lv_clr  = 1'b1;
    end else if (retry_grant_i && (st_sig == ST_WAIT_RETRY)) begin
      st_fet  = ST_WAIT_RESP;
    end
  end

  // stage 3: completion filter
  always_comb begin
    acc_o  = cmpl_hit_i && (st_fet == ST_WAIT_RESP) && (cmpl_tag_i == tag_nxt);
    drop_o = cmpl_hit_i && !acc_o;
    st_nxt = st_fet;
    if (acc_o) st_nxt = hold_any ? ST_BLOCK : ST_ACC_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      tag_q      <= '0;
      lv_q       <= 1'b0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      st_q    <= st_nxt;
      tag_q   <= tag_nxt;
      redir_q <= ld_pc;
      if (ld_pc) redir_pc_q <= new_pc;
      if (acc_o)       lv_q <= 1'b1;
      else if (lv_clr) lv_q <= 1'b0;
    end
  end

  assign st_o          = st_q;
  assign chg_o         = chg_sig | chg_fet;
  assign live_nxt_o    = st_is_live(st_nxt);
  assign line_valid_o  = lv_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = redir_pc_q;

endmodule

// File: rtl/fsc_activity.sv
module fsc_activity #(
  parameter int NUM_THREADS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] chg_i,
  input  logic [NUM_THREADS-1:0] acc_i,
  input  logic [NUM_THREADS-1:0] live_i,
  input  logic [NUM_THREADS-1:0] drop_i,
  output logic                   chg_o,
  output logic                   active_o,
  output logic                   drop_o
);
  logic chg_q, act_q, drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q  <= 1'b0;
      act_q  <= 1'b1;
      drop_q <= 1'b0;
    end else begin
      chg_q  <= |chg_i;
      drop_q <= |drop_i;
      if (|chg_i)      act_q <= |live_i;
      else if (|acc_i) act_q <= 1'b1;
    end
  end

  assign chg_o    = chg_q;
  assign active_o = act_q;
  assign drop_o   = drop_q;

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int PC_W        = 32,
  parameter int TAG_W       = 4,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [4*NUM_THREADS-1:0]      stall_set_i,
  input  logic [4*NUM_THREADS-1:0]      stall_clr_i,
  input  logic                          ctx_stall_i,
  input  logic [NUM_THREADS-1:0]        cmt_squash_i,
  input  logic [PC_W*NUM_THREADS-1:0]   cmt_pc_i,
  input  logic [NUM_THREADS-1:0]        rob_squashing_i,
  input  logic [NUM_THREADS-1:0]        dec_squash_i,
  input  logic [PC_W*NUM_THREADS-1:0]   dec_pc_i,
  input  logic                          fsel_valid_i,
  input  logic [TID_W-1:0]              fsel_tid_i,
  input  logic                          lreq_valid_i,
  input  logic [TID_W-1:0]              lreq_tid_i,
  input  logic [TAG_W-1:0]              lreq_tag_i,
  input  logic                          lreq_refused_i,
  input  logic [NUM_THREADS-1:0]        retry_grant_i,
  input  logic                          cmpl_valid_i,
  input  logic [TID_W-1:0]              cmpl_tid_i,
  input  logic [TAG_W-1:0]              cmpl_tag_i,
  output logic [4*NUM_THREADS-1:0]      status_o,
  output logic [4*NUM_THREADS-1:0]      stall_flags_o,
  output logic [NUM_THREADS-1:0]        line_valid_o,
  output logic [NUM_THREADS-1:0]        redirect_o,
  output logic [PC_W*NUM_THREADS-1:0]   redirect_pc_o,
  output logic                          status_chg_o,
  output logic                          stage_active_o,
  output logic                          stale_drop_o
);
  localparam int NFLAGS = NUM_THREADS * NUM_STAGES;

  logic [NFLAGS-1:0]      flags_nxt;
  logic [NUM_THREADS-1:0] chg_v, acc_v, drop_v, live_v;
  logic [NUM_THREADS-1:0] fsel_hit, lreq_hit, cmpl_hit;

  fsc_stall_bank #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_STAGES  (NUM_STAGES)
  ) u_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (stall_set_i),
    .clr_i       (stall_clr_i),
    .flags_q_o   (stall_flags_o),
    .flags_nxt_o (flags_nxt)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fetch_st_e st;

    assign fsel_hit[t] = fsel_valid_i && (fsel_tid_i == TID_W'(t));
    assign lreq_hit[t] = lreq_valid_i && (lreq_tid_i == TID_W'(t));
    assign cmpl_hit[t] = cmpl_valid_i && (cmpl_tid_i == TID_W'(t));

    fsc_thread_ctl #(
      .PC_W  (PC_W),
      .TAG_W (TAG_W)
    ) u_thr (
      .clk             (clk),
      .rst_n           (rst_n),
      .flags_nxt_i     (flags_nxt[t*NUM_STAGES +: NUM_STAGES]),
      .ctx_stall_i     (ctx_stall_i),
      .cmt_squash_i    (cmt_squash_i[t]),
      .cmt_pc_i        (cmt_pc_i[t*PC_W +: PC_W]),
      .rob_squashing_i (rob_squashing_i[t]),
      .dec_squash_i    (dec_squash_i[t]),
      .dec_pc_i        (dec_pc_i[t*PC_W +: PC_W]),
      .fsel_hit_i      (fsel_hit[t]),
      .lreq_hit_i      (lreq_hit[t]),
      .lreq_tag_i      (lreq_tag_i),
      .lreq_refused_i  (lreq_refused_i),
      .retry_grant_i   (retry_grant_i[t]),
      .cmpl_hit_i      (cmpl_hit[t]),
      .cmpl_tag_i      (cmpl_tag_i),
      .st_o            (st),
      .chg_o           (chg_v[t]),
      .acc_o           (acc_v[t]),
      .drop_o          (drop_v[t]),
      .live_nxt_o      (live_v[t]),
      .line_valid_o    (line_valid_o[t]),
      .redirect_o      (redirect_o[t]),
      .redirect_pc_o   (redirect_pc_o[t*PC_W +: PC_W])
    );

    assign status_o[t*4 +: 4] = st;
  end

  fsc_activity #(
    .NUM_THREADS (NUM_THREADS)
  ) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .chg_i    (chg_v),
    .acc_i    (acc_v),
    .live_i   (live_v),
    .drop_i   (drop_v),
    .chg_o    (status_chg_o),
    .active_o (stage_active_o),
    .drop_o   (stale_drop_o)
  );

endmodule

// File: rtl/fetch_status_ctrl_chk.sv
module fetch_status_ctrl_chk #(
  parameter int NUM_THREADS = 2,
  parameter int PC_W        = 32,
  parameter int TAG_W       = 4,
  parameter int TID_W       = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [4*NUM_THREADS-1:0] stall_set_i,
  input logic [4*NUM_THREADS-1:0] stall_clr_i,
  input logic [NUM_THREADS-1:0]   cmt_squash_i,
  input logic [NUM_THREADS-1:0]   rob_squashing_i,
  input logic [NUM_THREADS-1:0]   dec_squash_i,
  input logic                     cmpl_valid_i,
  input logic [TID_W-1:0]         cmpl_tid_i,
  input logic [4*NUM_THREADS-1:0] status_o,
  input logic [4*NUM_THREADS-1:0] stall_flags_o,
  input logic [NUM_THREADS-1:0]   line_valid_o,
  input logic [NUM_THREADS-1:0]   redirect_o,
  input logic                     status_chg_o,
  input logic                     stage_active_o
);

  function automatic logic any_live(logic [4*NUM_THREADS-1:0] sv);
    logic r = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++)
      if (sv[t*4 +: 4] == 4'd1 || sv[t*4 +: 4] == 4'd2 || sv[t*4 +: 4] == 4'd6) r = 1'b1;
    return r;
  endfunction

  p_set_clr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_set_i & stall_clr_i) == '0);

  p_clr_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_clr_i & ~stall_flags_o) == '0);

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|stall_set_i) |=> ((stall_flags_o & $past(stall_set_i)) == $past(stall_set_i)));

  p_active_recalc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    status_chg_o |-> (stage_active_o == any_live(status_o)));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr_chk
    p_cmt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash_i[t] |=> (status_o[t*4 +: 4] == 4'd2) && redirect_o[t]);

    p_rob_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_squashing_i[t] && !cmt_squash_i[t]) |=> (status_o[t*4 +: 4] == 4'd2) && !redirect_o[t]);

    p_wait_immune_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o[t*4 +: 4] == 4'd4) && !cmt_squash_i[t] && !rob_squashing_i[t] &&
       !dec_squash_i[t] && !(cmpl_valid_i && (cmpl_tid_i == TID_W'(t))))
      |=> (status_o[t*4 +: 4] == 4'd4));

    p_line_from_cmpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_valid_o[t]) |-> $past(cmpl_valid_i && (cmpl_tid_i == TID_W'(t))));
  end

endmodule

bind fetch_status_ctrl fetch_status_ctrl_chk #(
  .NUM_THREADS (NUM_THREADS),
  .PC_W        (PC_W),
  .TAG_W       (TAG_W),
  .TID_W       (TID_W)
) u_chk (.*);

// File: tb/test_fetch_status_ctrl.sv
`timescale 1ns/1ps
module test_fetch_status_ctrl;
  localparam int NT = 2;
  localparam int PW = 32;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4*NT-1:0]  stall_set_i = '0, stall_clr_i = '0;
  logic             ctx_stall_i = 1'b0;
  logic [NT-1:0]    cmt_squash_i = '0, rob_squashing_i = '0, dec_squash_i = '0, retry_grant_i = '0;
  logic [PW*NT-1:0] cmt_pc_i = '0, dec_pc_i = '0;
  logic             fsel_valid_i = 1'b0, lreq_valid_i = 1'b0, lreq_refused_i = 1'b0, cmpl_valid_i = 1'b0;
  logic [0:0]       fsel_tid_i = '0, lreq_tid_i = '0, cmpl_tid_i = '0;
  logic [TW-1:0]    lreq_tag_i = '0, cmpl_tag_i = '0;

  logic [4*NT-1:0]  status_o, stall_flags_o;
  logic [NT-1:0]    line_valid_o, redirect_o;
  logic [PW*NT-1:0] redirect_pc_o;
  logic             status_chg_o, stage_active_o, stale_drop_o;

  fetch_status_ctrl i_fetch_status_ctrl (.*);

  // staged stimulus for the next cycle
  logic [4*NT-1:0]  n_set, n_clr;
  logic             n_ctx;
  logic [NT-1:0]    n_cmt, n_rob, n_dec, n_rg;
  logic [PW*NT-1:0] n_cpc, n_dpc;
  logic             n_fsel, n_lreq, n_ref, n_cmpl;
  logic [0:0]       n_ftid, n_ltid, n_ctid;
  logic [TW-1:0]    n_ltag, n_ctag;

  task automatic clear_stage();
    n_set = '0; n_clr = '0; n_ctx = 0; n_cmt = '0; n_rob = '0; n_dec = '0; n_rg = '0;
    n_cpc = '0; n_dpc = '0; n_fsel = 0; n_lreq = 0; n_ref = 0; n_cmpl = 0;
    n_ftid = '0; n_ltid = '0; n_ctid = '0; n_ltag = '0; n_ctag = '0;
  endtask

  typedef struct {
    logic [4*NT-1:0]  st;
    logic [4*NT-1:0]  fl;
    logic [NT-1:0]    lv;
    logic [NT-1:0]    rd;
    logic [PW*NT-1:0] rpc;
    logic             chg;
    logic             act;
    logic             drop;
    string            req;
  } exp_t;

  exp_t sb[$];
  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  logic [3:0]    m_st  [NT];
  logic [3:0]    m_fl  [NT];
  logic [TW-1:0] m_tag [NT];
  logic          m_lv  [NT];
  logic          m_act;

  function automatic logic live(logic [3:0] s);
    return (s == 4'd1) || (s == 4'd2) || (s == 4'd6);
  endfunction

  task automatic model(input string req);
    exp_t e;
    logic any_chg, any_acc, any_live, any_drop;
    logic [3:0] fl, st;
    logic [TW-1:0] tg;
    logic hold, ch, rd, lv;
    logic [PW-1:0] pc;
    any_chg = 0; any_acc = 0; any_live = 0; any_drop = 0;
    e.rpc = '0;
    for (int t = 0; t < NT; t++) begin
      fl   = (m_fl[t] | stall_set_i[t*4 +: 4]) & ~stall_clr_i[t*4 +: 4];
      hold = (|fl) | ctx_stall_i;
      st = m_st[t]; ch = 0; rd = 0; pc = '0;
      if (cmt_squash_i[t]) begin st = 4'd2; ch = 1; rd = 1; pc = cmt_pc_i[t*PW +: PW]; end
      else if (rob_squashing_i[t]) begin st = 4'd2; ch = 1; end
      else if (dec_squash_i[t] && m_st[t] != 4'd2) begin st = 4'd2; ch = 1; rd = 1; pc = dec_pc_i[t*PW +: PW]; end
      else if (hold && m_st[t] != 4'd4 && m_st[t] != 4'd5) begin st = 4'd3; ch = 1; end
      else if (m_st[t] == 4'd3 || m_st[t] == 4'd2) begin st = 4'd1; ch = 1; end
      tg = m_tag[t]; lv = m_lv[t];
      if (fsel_valid_i && fsel_tid_i == 1'(t) && st == 4'd6) begin st = 4'd1; ch = 1; end
      else if (lreq_valid_i && lreq_tid_i == 1'(t) && st == 4'd1) begin
        st = lreq_refused_i ? 4'd5 : 4'd4; ch = 1; tg = lreq_tag_i; lv = 0;
      end else if (retry_grant_i[t] && st == 4'd5) st = 4'd4;
      if (cmpl_valid_i && cmpl_tid_i == 1'(t)) begin
        if (st == 4'd4 && cmpl_tag_i == tg) begin st = hold ? 4'd3 : 4'd6; lv = 1; any_acc = 1; end
        else any_drop = 1;
      end
      m_st[t] = st; m_fl[t] = fl; m_tag[t] = tg; m_lv[t] = lv;
      any_chg |= ch; any_live |= live(st);
      e.st[t*4 +: 4] = st; e.fl[t*4 +: 4] = fl; e.lv[t] = lv; e.rd[t] = rd;
      e.rpc[t*PW +: PW] = pc;
    end
    if (any_chg) m_act = any_live;
    else if (any_acc) m_act = 1'b1;
    e.chg = any_chg; e.act = m_act; e.drop = any_drop; e.req = req;
    sb.push_back(e);
  endtask

  task automatic step(input string req);
    @(negedge clk);
    stall_set_i = n_set; stall_clr_i = n_clr; ctx_stall_i = n_ctx;
    cmt_squash_i = n_cmt; cmt_pc_i = n_cpc; rob_squashing_i = n_rob;
    dec_squash_i = n_dec; dec_pc_i = n_dpc; retry_grant_i = n_rg;
    fsel_valid_i = n_fsel; fsel_tid_i = n_ftid;
    lreq_valid_i = n_lreq; lreq_tid_i = n_ltid; lreq_tag_i = n_ltag; lreq_refused_i = n_ref;
    cmpl_valid_i = n_cmpl; cmpl_tid_i = n_ctid; cmpl_tag_i = n_ctag;
    model(req);
    clear_stage();
  endtask

  // monitor: compares each result just after the edge that produced it
  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      logic bad;
      e = sb.pop_front();
      bad = (status_o !== e.st) || (stall_flags_o !== e.fl) || (line_valid_o !== e.lv) ||
            (redirect_o !== e.rd) || (status_chg_o !== e.chg) || (stage_active_o !== e.act) ||
            (stale_drop_o !== e.drop);
      for (int t = 0; t < NT; t++)
        if (e.rd[t] && redirect_pc_o[t*PW +: PW] !== e.rpc[t*PW +: PW]) bad = 1;
      n_vec++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: got st=%h fl=%h lv=%b rd=%b pc=%h chg=%b act=%b drop=%b exp st=%h fl=%h lv=%b rd=%b pc=%h chg=%b act=%b drop=%b",
                 e.req, status_o, stall_flags_o, line_valid_o, redirect_o, redirect_pc_o,
                 status_chg_o, stage_active_o, stale_drop_o,
                 e.st, e.fl, e.lv, e.rd, e.rpc, e.chg, e.act, e.drop);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clear_stage();
    for (int t = 0; t < NT; t++) begin m_st[t] = 4'd1; m_fl[t] = '0; m_tag[t] = '0; m_lv[t] = 0; end
    m_act = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    n_vec++;
    if (status_o !== 8'h11 || stall_flags_o !== '0 || line_valid_o !== '0 ||
        stage_active_o !== 1'b1 || status_chg_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got st=%h fl=%h lv=%b act=%b chg=%b exp st=11 fl=00 lv=00 act=1 chg=0",
               status_o, stall_flags_o, line_valid_o, stage_active_o, status_chg_o);
    end
    step("R1");

    // R2 / R6 / R7: per-stage hold flags
    n_set = 8'h01; step("R2");
    step("R6");
    n_clr = 8'h01; step("R7");
    n_set = 8'h80; step("R2");
    n_clr = 8'h80; step("R7");
    step("R7");
    n_ctx = 1; step("R6");
    step("R7");

    // R8 / R10: launch, hold while waiting, completion into Blocked
    n_lreq = 1; n_ltid = 0; n_ltag = 4'd5; step("R8");
    n_set = 8'h02; step("R6");
    n_cmpl = 1; n_ctid = 0; n_ctag = 4'd5; step("R10");
    n_clr = 8'h02; step("R7");

    // R11 / R12: stale filtering, then AccessDone waits for selection
    n_lreq = 1; n_ltid = 0; n_ltag = 4'd3; step("R8");
    n_cmpl = 1; n_ctid = 0; n_ctag = 4'd7; step("R11");
    n_cmpl = 1; n_ctid = 1; n_ctag = 4'd3; step("R11");
    n_cmpl = 1; n_ctid = 0; n_ctag = 4'd3; step("R10");
    step("R12");
    n_fsel = 1; n_ftid = 0; step("R12");
    n_lreq = 1; n_ltid = 1; n_ltag = 4'd4; n_cmpl = 0; step("R8");
    n_cmt = 2'b10; n_cpc = {32'h0000_0F00, 32'h0}; step("R3");
    step("R7");

    // R9 / R3: refused launch, grant, then commit abandons it
    n_lreq = 1; n_ltid = 1; n_ltag = 4'd9; n_ref = 1; step("R8");
    n_rg = 2'b10; step("R9");
    n_cmt = 2'b10; n_cpc = {32'h0000_1000, 32'h0}; step("R3");
    n_cmpl = 1; n_ctid = 1; n_ctag = 4'd9; step("R3");

    // R4 / R3 / R5: stacked redirect sources
    n_rob = 2'b01; step("R4");
    n_rob = 2'b01; step("R4");
    n_cmt = 2'b01; n_cpc = {32'h0, 32'h0000_A000}; n_dec = 2'b01; n_dpc = {32'h0, 32'h0000_B000};
    n_rob = 2'b01; step("R3");
    step("R7");
    n_dec = 2'b01; n_dpc = {32'h0, 32'h0000_2000}; step("R5");
    n_dec = 2'b01; n_dpc = {32'h0, 32'h0000_3000}; step("R5");
    n_set = 8'h40; n_cmt = 2'b10; n_cpc = {32'h0000_4000, 32'h0}; step("R3");
    step("R6");
    n_clr = 8'h40; step("R7");

    // R13: both threads waiting clears activity, completion raises it
    n_lreq = 1; n_ltid = 0; n_ltag = 4'd1; step("R8");
    n_lreq = 1; n_ltid = 1; n_ltag = 4'd2; step("R13");
    n_ctx = 1; step("R6");
    n_cmpl = 1; n_ctid = 0; n_ctag = 4'd1; step("R13");
    n_cmpl = 1; n_ctid = 1; n_ctag = 4'd2; n_ctx = 1; step("R10");
    step("R13");
    n_fsel = 1; n_ftid = 0; step("R12");
    step("R7");

    repeat (3) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule